// File: doc/BRIEF.md
# Synchronous Serial Shift Transceiver

This block moves bytes over a clocked serial link. It produces the shift clock and the transmit data line, and it captures an incoming data line at the same time. A baud generator outside the block supplies single-cycle tick pulses. Each tick advances the link by one half bit. One tick starts the low half of the bit and shifts out new transmit data. The next tick starts the high half and samples the receive line. Bytes are eight bits wide by default and travel least significant bit first in both directions.

A transmit byte enters a one-entry holding buffer through a valid/ready handshake. At the end of each frame the buffer is moved into the transmit shift register. A byte that is already waiting therefore starts on the very next tick, with no idle half bit between frames. If nothing is waiting, the block parks with the clock high and the data line high. Each received byte appears on the receive bus together with a one-cycle valid strobe.

The control state machine has three states. PH_IDLE means the link is stopped. PH_LOW means the clock is low and the next tick will sample. PH_HIGH means the clock is high and the next tick will shift or end the frame. The transitions are:
- START goes from PH_IDLE to PH_LOW, on a tick while the buffer holds a byte.
- LATCH goes from PH_LOW to PH_HIGH, on any tick.
- SHIFT goes from PH_HIGH to PH_LOW, on a tick while bits remain in the frame.
- CHAIN goes from PH_HIGH to PH_LOW, on a tick after the last bit while the buffer holds a byte.
- STOP goes from PH_HIGH to PH_IDLE, on a tick after the last bit while the buffer is empty.

Top module: `sync_shift_xcvr`

## Requirements
- R1: `sclk_o` is high whenever the link is stopped. It changes level only in the cycle after a cycle in which `tick_i` was high.
- R2: `sdo_o` changes only together with a falling `sclk_o`. It keeps its value across every rising `sclk_o`.
- R3: Each frame puts the 8 bits of the transmitted byte on `sdo_o`, bit 0 first and bit 7 last, one bit per low/high clock period.
- R4: On each tick that raises `sclk_o`, the value of `sdi_i` in that cycle is captured. The first capture of a frame becomes bit 0 and the eighth becomes bit 7. In the cycle after the eighth capture, `rx_valid_o` is high for exactly one cycle and `rx_data_o` holds the byte. `rx_data_o` keeps that value until the next byte arrives.
- R5: `tx_ready_o` is high exactly when the one-byte buffer is empty. A byte is accepted on a clock edge where `tx_valid_i` and `tx_ready_o` are both high. A held byte is not altered before it is used.
- R6: If the buffer holds a byte when a frame ends, bit 0 of that byte is driven on the next tick. Over a burst of consecutive frames, the falling clock edges then keep a spacing of two ticks.
- R7: If the buffer is empty when a frame ends, the next tick stops the link with `sclk_o` and `sdo_o` both high.
- R8: While `rst_n` is low, the buffer and both shift registers are cleared and any frame in progress is dropped. The outputs are then `sclk_o`=1, `sdo_o`=1, `tx_ready_o`=1, `rx_valid_o`=0 and `rx_data_o`=0.
- R9: A frame starts only on a tick while the buffer holds a byte. Ticks with an empty buffer leave `sclk_o` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Half-bit advance pulse from the baud generator |
| tx_data_i | input | 8 | Byte offered for transmission |
| tx_valid_i | input | 1 | `tx_data_i` is valid |
| tx_ready_o | output | 1 | Holding buffer is empty and can accept a byte |
| rx_data_o | output | 8 | Last byte received |
| rx_valid_o | output | 1 | One-cycle strobe marking a new `rx_data_o` |
| sclk_o | output | 1 | Shift clock; idles high |
| sdo_o | output | 1 | Serial transmit data |
| sdi_i | input | 1 | Serial receive data |

## Verification
The assertions assume that `tick_i` is a clean, synchronous, single-cycle-wide signal. They also assume it can be high on any number of consecutive cycles, so one tick per clock is legal and is the fastest rate. The receive-strobe property relies on a frame taking at least sixteen ticks. The stimulus runs ticks on every cycle, on every third cycle, and on a pseudo-random pattern. It only changes `tick_i`, `tx_valid_i`, `tx_data_i` and `sdi_i` at the falling clock edge, and it holds `tx_data_i` steady while a handshake is pending.

// File: rtl/sst_pkg.sv
package sst_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2
    } phase_e;

endpackage

// File: rtl/sst_txbuf.sv
module sst_txbuf #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              take_i,
    output logic              ready_o,
    output logic              full_o,
    output logic [DATA_W-1:0] data_o
);

    logic              full_q;
    logic [DATA_W-1:0] data_q;
    logic              accept;

    assign accept = wr_valid_i && !full_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            full_q <= 1'b0;
            data_q <= '0;
        end else if (accept) begin
            full_q <= 1'b1;
            data_q <= wr_data_i;
        end else if (take_i) begin
            full_q <= 1'b0;
        end
    end

    assign ready_o = !full_q;
    assign full_o  = full_q;
    assign data_o  = data_q;

    AST_BUF_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (full_q && !take_i) |=> (full_q && $stable(data_q))); // R5

endmodule

// File: rtl/sst_rxcap.sv
module sst_rxcap #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              latch_i,
    input  logic              last_i,
    input  logic              sdi_i,
    output logic [DATA_W-1:0] data_o,
    output logic              valid_o
);

    logic [DATA_W-1:0] sr_q;
    logic [DATA_W-1:0] sr_next;
    logic [DATA_W-1:0] data_q;
    logic              valid_q;

    assign sr_next = {sdi_i, sr_q[DATA_W-1:1]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q    <= '0;
            data_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            if (latch_i) begin
                sr_q <= sr_next;
                if (last_i) begin
                    data_q  <= sr_next;
                    valid_q <= 1'b1;
                end
            end
        end
    end

    assign data_o  = data_q;
    assign valid_o = valid_q;

    AST_RX_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |=> !valid_q); // R4

    AST_RX_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_q |-> $stable(data_q)); // R4

endmodule

// File: rtl/sst_ctrl.sv
module sst_ctrl
    import sst_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              buf_full_i,
    input  logic [DATA_W-1:0] buf_data_i,
    output logic              take_o,
    output logic              latch_o,
    output logic              last_o,
    output logic              sclk_o,
    output logic              sdo_o
);

    localparam int                CNT_W    = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DATA_W);

    phase_e            state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [DATA_W-1:0] sr_q;
    logic              sclk_q, sdo_q;
    logic              take, shift, latch, stop;
    logic              frame_end;

    assign frame_end = (cnt_q == FULL_CNT);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PH_IDLE;
        else        state_q <= state_d;
    end

    // next state and phase strobes
    always_comb begin
        state_d = state_q;
        take    = 1'b0;
        shift   = 1'b0;
        latch   = 1'b0;
        stop    = 1'b0;
        unique case (state_q)
            PH_IDLE: begin
                if (tick_i && buf_full_i) begin
                    take    = 1'b1;          // START
                    state_d = PH_LOW;
                end
            end
            PH_LOW: begin
                if (tick_i) begin
                    latch   = 1'b1;          // LATCH
                    state_d = PH_HIGH;
                end
            end
            PH_HIGH: begin
                if (tick_i) begin
                    if (!frame_end) begin
                        shift   = 1'b1;      // SHIFT
                        state_d = PH_LOW;
                    end else if (buf_full_i) begin
                        take    = 1'b1;      // CHAIN
                        state_d = PH_LOW;
                    end else begin
                        stop    = 1'b1;      // STOP
                        state_d = PH_IDLE;
                    end
                end
            end
            default: state_d = PH_IDLE;
        endcase
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q   <= '0;
            cnt_q  <= '0;
            sclk_q <= 1'b1;
            sdo_q  <= 1'b1;
        end else if (take) begin
            sr_q   <= buf_data_i;
            cnt_q  <= '0;
            sclk_q <= 1'b0;
            sdo_q  <= buf_data_i[0];
        end else if (shift) begin
            sr_q   <= sr_q >> 1;
            sclk_q <= 1'b0;
            sdo_q  <= sr_q[1];
        end else if (latch) begin
            sclk_q <= 1'b1;
            cnt_q  <= cnt_q + 1'b1;
        end else if (stop) begin
            sdo_q  <= 1'b1;
        end
    end

    assign take_o  = take;
    assign latch_o = latch;
    assign last_o  = latch && (cnt_q == FULL_CNT - 1'b1);
    assign sclk_o  = sclk_q;
    assign sdo_o   = sdo_q;

    AST_SCLK_PARKED_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PH_IDLE) |-> sclk_q); // R1

    AST_SCLK_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sclk_q) |-> $past(tick_i)); // R1

    AST_SDO_STEADY_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk_q) |-> $stable(sdo_q)); // R2

    AST_SDO_MOVES_WITH_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(sdo_q) && sclk_q) |-> (state_q == PH_IDLE)); // R2

    AST_PARKED_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PH_IDLE) |-> sdo_q); // R7

    AST_START_NEEDS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sclk_q) |-> ($past(buf_full_i) || $past(state_q) == PH_HIGH)); // R9

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= FULL_CNT); // R3

endmodule

// File: rtl/sync_shift_xcvr.sv
module sync_shift_xcvr #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic [DATA_W-1:0] tx_data_i,
    input  logic              tx_valid_i,
    output logic              tx_ready_o,
    output logic [DATA_W-1:0] rx_data_o,
    output logic              rx_valid_o,
    output logic              sclk_o,
    output logic              sdo_o,
    input  logic              sdi_i
);

    logic              buf_full;
    logic [DATA_W-1:0] buf_data;
    logic              take;
    logic              latch;
    logic              last;

    sst_txbuf #(.DATA_W(DATA_W)) u_txbuf (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_valid_i (tx_valid_i),
        .wr_data_i  (tx_data_i),
        .take_i     (take),
        .ready_o    (tx_ready_o),
        .full_o     (buf_full),
        .data_o     (buf_data)
    );

    sst_ctrl #(.DATA_W(DATA_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick_i),
        .buf_full_i (buf_full),
        .buf_data_i (buf_data),
        .take_o     (take),
        .latch_o    (latch),
        .last_o     (last),
        .sclk_o     (sclk_o),
        .sdo_o      (sdo_o)
    );

    sst_rxcap #(.DATA_W(DATA_W)) u_rxcap (
        .clk     (clk),
        .rst_n   (rst_n),
        .latch_i (latch),
        .last_i  (last),
        .sdi_i   (sdi_i),
        .data_o  (rx_data_o),
        .valid_o (rx_valid_o)
    );

    AST_TAKE_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> buf_full); // R5

    AST_TAKE_FREES_BUF: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> tx_ready_o); // R5

endmodule

// File: tb/sync_shift_xcvr_tb_top.sv
module sync_shift_xcvr_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b0;
    logic [7:0] tx_data_i = 8'h00;
    logic       tx_valid_i = 1'b0;
    logic       tx_ready_o;
    logic [7:0] rx_data_o;
    logic       rx_valid_o;
    logic       sclk_o;
    logic       sdo_o;
    logic       sdi_i = 1'b1;

    always #5 clk = ~clk;

    sync_shift_xcvr #(.DATA_W(8)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick_i),
        .tx_data_i  (tx_data_i),
        .tx_valid_i (tx_valid_i),
        .tx_ready_o (tx_ready_o),
        .rx_data_o  (rx_data_o),
        .rx_valid_o (rx_valid_o),
        .sclk_o     (sclk_o),
        .sdo_o      (sdo_o),
        .sdi_i      (sdi_i)
    );

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // behavioural reference model
    int         m_ph;      // 0 stopped, 1 clock low, 2 clock high
    int         m_bit;
    logic [7:0] m_cur, m_buf, m_racc, m_rxd;
    logic       m_full, m_sclk, m_sdo, m_rxv, m_acc, m_ld;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_ph = 0; m_bit = 0; m_cur = 0; m_buf = 0; m_racc = 0; m_rxd = 0;
            m_full = 0; m_sclk = 1; m_sdo = 1; m_rxv = 0;
        end else begin
            m_acc = tx_valid_i && !m_full;
            m_ld  = 0;
            m_rxv = 0;
            if (tick_i) begin
                case (m_ph)
                    0: if (m_full) m_ld = 1;
                    1: begin
                        m_sclk = 1;
                        m_racc[m_bit] = sdi_i;
                        m_bit++;
                        if (m_bit == 8) begin m_rxv = 1; m_rxd = m_racc; end
                        m_ph = 2;
                    end
                    default: begin
                        if (m_bit == 8) begin
                            if (m_full) m_ld = 1;
                            else begin m_ph = 0; m_sdo = 1; end
                        end else begin
                            m_sdo = m_cur[m_bit]; m_sclk = 0; m_ph = 1;
                        end
                    end
                endcase
            end
            if (m_ld) begin
                m_cur = m_buf; m_bit = 0; m_sdo = m_buf[0]; m_sclk = 0;
                m_ph = 1; m_full = 0;
            end
            if (m_acc) begin m_full = 1; m_buf = tx_data_i; end
        end
    end

    // stimulus and observation state
    byte unsigned drv_q[$];
    byte unsigned sent_q[$];
    byte unsigned got_q[$];
    bit           pend = 0;
    int           tick_mode = 3;
    int           cyc = 0;
    logic [15:0]  lfsr = 16'hACE1;
    logic         prev_sclk = 1'b1;
    logic [7:0]   obs_acc = 8'h00;
    int           obs_bit = 0;
    int           falls = 0;
    int           first_fall = -1;
    int           last_fall = -1;

    always @(negedge clk) begin
        cyc++;
        // per-cycle comparison against the model
        chk("R1", "sclk_o", {31'd0, sclk_o}, {31'd0, m_sclk});
        chk("R3", "sdo_o", {31'd0, sdo_o}, {31'd0, m_sdo});
        chk("R5", "tx_ready_o", {31'd0, tx_ready_o}, {31'd0, !m_full});
        chk("R4", "rx_valid_o", {31'd0, rx_valid_o}, {31'd0, m_rxv});
        chk("R4", "rx_data_o", {24'd0, rx_data_o}, {24'd0, m_rxd});
        // serial observer: sample sdo at each rising shift clock
        if (rst_n) begin
            if (sclk_o && !prev_sclk) begin
                obs_acc[obs_bit] = sdo_o;
                obs_bit++;
                if (obs_bit == 8) begin got_q.push_back(obs_acc); obs_bit = 0; end
            end
            if (!sclk_o && prev_sclk) begin
                falls++;
                if (first_fall < 0) first_fall = cyc;
                last_fall = cyc;
            end
        end
        prev_sclk = sclk_o;
        // stimulus
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        sdi_i = lfsr[0];
        case (tick_mode)
            0:       tick_i = 1'b1;
            1:       tick_i = (cyc % 3 == 0);
            2:       tick_i = lfsr[5];
            default: tick_i = 1'b0;
        endcase
        if (pend) sent_q.push_back(drv_q.pop_front());
        if (drv_q.size() > 0) begin tx_valid_i = 1'b1; tx_data_i = drv_q[0]; end
        else tx_valid_i = 1'b0;
        pend = tx_valid_i && tx_ready_o && rst_n;
    end

    task automatic wait_idle();
        for (int i = 0; i < 20000; i++) begin
            @(posedge clk); #2;
            if (drv_q.size() == 0 && !pend && !tx_valid_i && m_ph == 0 && !m_full) break;
        end
        repeat (4) @(posedge clk);
        #2;
    endtask

    task automatic cmp_tx(input string tag);
        chk("R3", {tag, " byte count"}, got_q.size(), sent_q.size());
        for (int i = 0; i < sent_q.size() && i < got_q.size(); i++)
            chk("R3", {tag, " serial byte"}, {24'd0, got_q[i]}, {24'd0, sent_q[i]});
        got_q.delete();
        sent_q.delete();
    endtask

    task automatic clear_falls();
        falls = 0; first_fall = -1; last_fall = -1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2;
        // R8: reset values
        chk("R8", "reset sclk", {31'd0, sclk_o}, 32'd1);
        chk("R8", "reset sdo", {31'd0, sdo_o}, 32'd1);
        chk("R8", "reset ready", {31'd0, tx_ready_o}, 32'd1);
        chk("R8", "reset rx_valid", {31'd0, rx_valid_o}, 32'd0);
        chk("R8", "reset rx_data", {24'd0, rx_data_o}, 32'd0);
        rst_n = 1'b1;

        // single byte, slow ticks
        tick_mode = 1;
        drv_q.push_back(8'hA5);
        wait_idle();
        chk("R7", "parked sclk", {31'd0, sclk_o}, 32'd1);
        chk("R7", "parked sdo", {31'd0, sdo_o}, 32'd1);
        cmp_tx("single");

        // back-to-back burst at one tick per cycle
        tick_mode = 3;
        repeat (3) @(posedge clk);
        #2;
        clear_falls();
        tick_mode = 0;
        drv_q.push_back(8'h3C); drv_q.push_back(8'h81); drv_q.push_back(8'hF0);
        wait_idle();
        chk("R6", "burst fall count", falls, 32'd24);
        chk("R6", "burst fall span", last_fall - first_fall, 32'd46);
        cmp_tx("burst");

        // irregular ticks
        tick_mode = 2;
        for (int i = 0; i < 5; i++) drv_q.push_back(lfsr[7:0] ^ byte'(i * 37));
        wait_idle();
        cmp_tx("irregular");

        // reset in the middle of a frame
        tick_mode = 0;
        drv_q.push_back(8'hFF); drv_q.push_back(8'h00);
        repeat (7) @(posedge clk);
        #2;
        rst_n = 1'b0;
        drv_q.delete();
        pend = 0;
        obs_bit = 0;
        repeat (2) @(posedge clk);
        #2;
        chk("R8", "abort sclk", {31'd0, sclk_o}, 32'd1);
        chk("R8", "abort sdo", {31'd0, sdo_o}, 32'd1);
        chk("R8", "abort ready", {31'd0, tx_ready_o}, 32'd1);
        sent_q.delete(); got_q.delete();
        rst_n = 1'b1;
        clear_falls();
        repeat (10) @(posedge clk);
        #2;
        chk("R9", "no start without byte", falls, 32'd0);
        chk("R9", "sclk parked", {31'd0, sclk_o}, 32'd1);
        drv_q.push_back(8'h5A);
        wait_idle();
        cmp_tx("after reset");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > 150000 && !done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog run did not complete actual=%0d expected=<150000", wd);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule